// File: doc/BRIEF.md
# Address Window to Partition Lookup

This block decides which isolation domain (partition) owns an incoming memory-mapped address. It holds a table of programmable windows. Each window has a base and a mask, so it covers a naturally aligned power-of-two range. A window resolves a matching address to a partition number in one of four ways:

- **Single:** the whole window belongs to one programmed partition.
- **Identity:** the window is split into one segment per partition, and segment n goes to partition n.
- **Table:** the window is split into a few segments, each with its own programmable partition.
- **Offset:** the window is split into 8, 64 or 128 segments, and segment n goes to a programmed starting partition plus n.

Software fills the table through a write port, one operation per write. An operation sets the base, sets the mask, sets the mode word, fills one table segment, enables a window or disables a window. Writes that would leave a window in an illegal state are refused, and each refusal raises a one-cycle error flag. A lookup presents an address with a valid strobe. One cycle later the block returns a hit flag and the owning partition.

Top module: `addr_part_lookup`

## Requirements
- R1: A lookup hits on a window only when that window is enabled and (address AND mask) equals its base.
- R2: In single mode (mode code 0), every address in the window returns the partition field of the mode word. The mode word is written with op 2 and has mode in bits [1:0], segment-count code in bits [3:2] and partition/base in bits [15:8].
- R3: In identity mode (mode code 1), the window is split into 256 equal segments, and segment n returns partition n.
- R4: In table mode (mode code 2), the window is split into 8 equal segments. Segment k returns the partition written by op 3 with wr_idx = k and the value in wr_data[7:0].
- R5: In offset mode (mode code 3), segment-count code 0, 1 or 2 gives 8, 64 or 128 segments. Segment n returns the partition field plus n.
- R6: A mode write that asks for offset mode with count code 3, or with a partition field that is not a multiple of the segment count, is refused. It pulses prog_err for one cycle and leaves the window's previous configuration intact.
- R7: An enable (op 4) is refused, with a prog_err pulse and the window left disabled, in either of two cases. The base has bits set below the mask. Or the window is in single mode and smaller than 32 MB (mask lowest set bit below 25).
- R8: An enable carries a split request in wr_data[0]. It is refused with prog_err if the request does not match the configured mode: 0 for single, 1 for the three segmented modes.
- R9: When several enabled windows match, the lowest-numbered window decides the partition.
- R10: A lookup that matches no enabled window returns out_hit = 0 and out_part = 0.
- R11: out_valid follows in_valid one cycle later, and the result appears on that cycle.
- R12: A table write takes effect for lookups presented on the following cycle. A lookup in the same cycle as the write sees the old table.
- R13: The table has 16 windows addressed by wr_win, up to window 15. A disable write (op 5) stops the window from matching.
- R14: After reset, all windows are disabled, and out_valid, out_hit and prog_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 40 | Address to resolve |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_hit | output | 1 | An enabled window matched |
| out_part | output | 8 | Owning partition, 0 on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_win | input | 4 | Window addressed by the write |
| wr_op | input | 3 | 0 base, 1 mask, 2 mode word, 3 table segment, 4 enable, 5 disable |
| wr_idx | input | 3 | Segment number for op 3 |
| wr_data | input | 40 | Write operand |
| prog_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench builds the block with its default parameters: 16 windows, 40-bit addresses, 8-bit partitions, an 8-segment table and a 25-bit single-mode floor. With 40-bit addresses, the bench can place 32 MB single windows, a 4 GB identity window carrying all 256 partitions, and offset windows of each segment count side by side at distinct bases. Windows 5 and 7 overlap windows 1 and 6, which exercises the priority rule. Window 15 checks the top of the table. A write and a lookup are issued in the same cycle to confirm which table a lookup sees.

// File: rtl/awp_pkg.sv
package awp_pkg;

    parameter int ADDR_W   = 40;
    parameter int PART_W   = 8;
    parameter int MAP_SEGS = 8;

    localparam int MAP_IDX_W = $clog2(MAP_SEGS);
    localparam int SHIFT_W   = $clog2(ADDR_W + 1);

    // mode word field positions inside wr_data
    localparam int MW_MODE_LSB = 0;
    localparam int MW_SEGC_LSB = 2;
    localparam int MW_PART_LSB = 8;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_TABLE  = 2'd2,
        MODE_OFFSET = 2'd3
    } map_mode_e;

    typedef enum logic [2:0] {
        OP_BASE    = 3'd0,
        OP_MASK    = 3'd1,
        OP_MODE    = 3'd2,
        OP_SEG     = 3'd3,
        OP_ENABLE  = 3'd4,
        OP_DISABLE = 3'd5
    } prog_op_e;

    typedef struct packed {
        logic                             en;
        map_mode_e                        mode;
        logic [1:0]                       segc;
        logic [PART_W-1:0]                part;
        logic [ADDR_W-1:0]                base;
        logic [ADDR_W-1:0]                mask;
        logic [MAP_SEGS-1:0][PART_W-1:0]  segmap;
    } win_cfg_t;

    // log2 of the window size: position of the lowest set mask bit
    function automatic logic [SHIFT_W-1:0] mask_log2(input logic [ADDR_W-1:0] m);
        logic [SHIFT_W-1:0] n;
        n = SHIFT_W'(ADDR_W);
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (m[i]) n = SHIFT_W'(i);
        end
        return n;
    endfunction

    // log2 of the number of segments a mode splits a window into
    function automatic logic [SHIFT_W-1:0] seg_log2(input map_mode_e md, input logic [1:0] sc);
        logic [SHIFT_W-1:0] r;
        case (md)
            MODE_IDENT:  r = SHIFT_W'(PART_W);
            MODE_TABLE:  r = SHIFT_W'(MAP_IDX_W);
            MODE_OFFSET: begin
                case (sc)
                    2'd0:    r = SHIFT_W'(3);
                    2'd1:    r = SHIFT_W'(6);
                    default: r = SHIFT_W'(7);
                endcase
            end
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/awp_prog.sv
module awp_prog
    import awp_pkg::*;
#(
    parameter int NUM_WIN         = 16,
    parameter int MIN_SINGLE_LOG2 = 25,
    localparam int WIN_W          = $clog2(NUM_WIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WIN_W-1:0]     wr_win,
    input  logic [2:0]           wr_op,
    input  logic [MAP_IDX_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0]    wr_data,
    output win_cfg_t             tbl [NUM_WIN],
    output logic                 prog_err
);

    localparam logic [SHIFT_W-1:0] MIN_LG = SHIFT_W'(MIN_SINGLE_LOG2);

    win_cfg_t           cur;
    map_mode_e          req_mode;
    logic [1:0]         req_segc;
    logic [PART_W-1:0]  req_part;
    logic [PART_W-1:0]  low_bits;
    logic               mode_bad;
    logic [SHIFT_W-1:0] cur_sz;
    logic               cur_split;
    logic               en_bad;
    logic               win_ok;

    always_comb begin
        win_ok   = 32'(wr_win) < NUM_WIN;
        cur      = tbl[wr_win];
        req_mode = map_mode_e'(wr_data[MW_MODE_LSB +: 2]);
        req_segc = wr_data[MW_SEGC_LSB +: 2];
        req_part = wr_data[MW_PART_LSB +: PART_W];
        low_bits = ~({PART_W{1'b1}} << seg_log2(req_mode, req_segc));
        mode_bad = (req_mode == MODE_OFFSET) &&
                   ((req_segc == 2'd3) || ((req_part & low_bits) != '0));

        cur_sz    = mask_log2(cur.mask);
        cur_split = (cur.mode != MODE_SINGLE);
        en_bad    = (wr_data[0] != cur_split)
                 || ((cur.base & ~cur.mask) != '0)
                 || (!cur_split && (cur_sz < MIN_LG))
                 || ( cur_split && (cur_sz < seg_log2(cur.mode, cur.segc)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WIN; w++) tbl[w] <= '0;
            prog_err <= 1'b0;
        end else begin
            prog_err <= 1'b0;
            if (wr_en && win_ok) begin
                case (prog_op_e'(wr_op))
                    OP_BASE: tbl[wr_win].base <= wr_data;
                    OP_MASK: tbl[wr_win].mask <= wr_data;
                    OP_MODE: begin
                        if (mode_bad) begin
                            prog_err <= 1'b1;
                        end else begin
                            tbl[wr_win].mode <= req_mode;
                            tbl[wr_win].segc <= req_segc;
                            tbl[wr_win].part <= req_part;
                        end
                    end
                    OP_SEG: tbl[wr_win].segmap[wr_idx] <= wr_data[PART_W-1:0];
                    OP_ENABLE: begin
                        tbl[wr_win].en <= !en_bad;
                        prog_err       <= en_bad;
                    end
                    OP_DISABLE: tbl[wr_win].en <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // an error pulse always follows a write
    p_err_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> $past(wr_en));

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
        p_disable_clears_r13: assert property (@(posedge clk) disable iff (rst)
            (wr_en && 32'(wr_win) == w && wr_op == OP_DISABLE) |=> !tbl[w].en);
        p_refused_enable_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && 32'(wr_win) == w && wr_op == OP_ENABLE && en_bad)
            |=> (!tbl[w].en && prog_err));
    end

endmodule

// File: rtl/awp_win_match.sv
module awp_win_match
    import awp_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PART_W-1:0] part
);

    logic [SHIFT_W-1:0] sz;
    logic [SHIFT_W-1:0] sh;
    logic [ADDR_W-1:0]  off;
    logic [ADDR_W-1:0]  idx;

    always_comb begin
        hit = cfg.en && ((addr & cfg.mask) == cfg.base);
        sz  = mask_log2(cfg.mask);
        sh  = sz - seg_log2(cfg.mode, cfg.segc);
        off = addr & ~cfg.mask;
        idx = off >> sh;
        case (cfg.mode)
            MODE_IDENT:  part = PART_W'(idx);
            MODE_TABLE:  part = cfg.segmap[MAP_IDX_W'(idx)];
            MODE_OFFSET: part = cfg.part + PART_W'(idx);
            default:     part = cfg.part;
        endcase
    end

endmodule

// File: rtl/awp_prio.sv
module awp_prio
    import awp_pkg::*;
#(
    parameter int NUM_WIN = 16
) (
    input  logic [NUM_WIN-1:0] hits,
    input  logic [PART_W-1:0]  parts [NUM_WIN],
    output logic               any,
    output logic [NUM_WIN-1:0] sel,
    output logic [PART_W-1:0]  part
);

    always_comb begin
        any  = 1'b0;
        sel  = '0;
        part = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any  = 1'b1;
                sel  = '0;
                sel[w] = 1'b1;
                part = parts[w];
            end
        end
    end

endmodule

// File: rtl/addr_part_lookup.sv
module addr_part_lookup
    import awp_pkg::*;
#(
    parameter int NUM_WIN         = 16,
    parameter int MIN_SINGLE_LOG2 = 25,
    localparam int WIN_W          = $clog2(NUM_WIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [PART_W-1:0]    out_part,
    input  logic                 wr_en,
    input  logic [WIN_W-1:0]     wr_win,
    input  logic [2:0]           wr_op,
    input  logic [MAP_IDX_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0]    wr_data,
    output logic                 prog_err
);

    win_cfg_t           tbl [NUM_WIN];
    logic [NUM_WIN-1:0] hits;
    logic [PART_W-1:0]  parts [NUM_WIN];
    logic [NUM_WIN-1:0] sel;
    logic [NUM_WIN-1:0] en_vec;
    logic               any;
    logic [PART_W-1:0]  win_part;

    awp_prog #(
        .NUM_WIN         (NUM_WIN),
        .MIN_SINGLE_LOG2 (MIN_SINGLE_LOG2)
    ) i_prog (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_win   (wr_win),
        .wr_op    (wr_op),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .tbl      (tbl),
        .prog_err (prog_err)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        awp_win_match i_match (
            .cfg  (tbl[w]),
            .addr (in_addr),
            .hit  (hits[w]),
            .part (parts[w])
        );
        assign en_vec[w] = tbl[w].en;
    end

    awp_prio #(.NUM_WIN(NUM_WIN)) i_prio (
        .hits  (hits),
        .parts (parts),
        .any   (any),
        .sel   (sel),
        .part  (win_part)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_part  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && any;
            out_part  <= (in_valid && any) ? win_part : '0;
        end
    end

    p_valid_follows_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follows_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> (out_part == '0));
    p_single_owner_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    p_hit_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && any) |-> (en_vec != '0));

endmodule

// File: tb/test_addr_part_lookup.sv
`timescale 1ns/1ps
module test_addr_part_lookup;
    import awp_pkg::*;

    localparam int CLK_NS = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [39:0]       in_addr = '0;
    logic              out_valid, out_hit, prog_err;
    logic [7:0]        out_part;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_win = '0;
    logic [2:0]        wr_op = '0;
    logic [2:0]        wr_idx = '0;
    logic [39:0]       wr_data = '0;

    int total = 0;
    int bad   = 0;

    always #(CLK_NS/2) clk = ~clk;

    addr_part_lookup i_addr_part_lookup (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_part(out_part),
        .wr_en(wr_en), .wr_win(wr_win), .wr_op(wr_op), .wr_idx(wr_idx),
        .wr_data(wr_data), .prog_err(prog_err)
    );

    typedef struct packed {
        logic [39:0] a;
        logic        h;
        logic [7:0]  p;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{40'h00_4000_0000, 1'b1, 8'h21},  // R2 single, low end
        '{40'h00_41FF_FFFF, 1'b1, 8'h21},  // R2 single, high end
        '{40'h00_4200_0000, 1'b0, 8'h00},  // R1 just past window
        '{40'h10_0000_0000, 1'b1, 8'h00},  // R3 / R9 overlap with window 5
        '{40'h10_AB12_3456, 1'b1, 8'hAB},  // R3
        '{40'h10_FFFF_FFFF, 1'b1, 8'hFF},  // R3 last segment
        '{40'h20_0000_0000, 1'b1, 8'h80},  // R4 seg 0
        '{40'h20_0000_2000, 1'b1, 8'h83},  // R4 seg 1
        '{40'h20_0000_FFFF, 1'b1, 8'h95},  // R4 seg 7
        '{40'h30_0000_0000, 1'b1, 8'h40},  // R5 64 segs
        '{40'h30_000F_C000, 1'b1, 8'h7F},  // R5 last of 64
        '{40'h30_0004_4000, 1'b1, 8'h51},  // R5 seg 17
        '{40'hA0_0000_FE00, 1'b1, 8'hFF},  // R5 128 segs, last
        '{40'hB0_0000_0A00, 1'b1, 8'h0D},  // R5 8 segs, seg 5
        '{40'h40_0000_0010, 1'b1, 8'h55},  // R9 window 6 beats 7
        '{40'h50_0000_0000, 1'b0, 8'h00}   // R10 nothing there
    };

    localparam logic [39:0] M32M = 40'hFF_FE00_0000;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] mw(input logic [1:0] md, input logic [1:0] sc, input logic [7:0] pt);
        return {24'd0, pt, 4'd0, sc, md};
    endfunction

    task automatic wr(input int w, input logic [2:0] op, input int idx,
                      input logic [39:0] d, output logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_win = w[3:0]; wr_op = op; wr_idx = idx[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = prog_err;
    endtask

    task automatic look(input logic [39:0] a, output logic v, output logic h, output logic [7:0] p);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        v = out_valid; h = out_hit; p = out_part;
    endtask

    task automatic setup(input int w, input logic [39:0] b, input logic [39:0] m, input logic [39:0] mword);
        logic e;
        wr(w, 3'd0, 0, b, e);
        wr(w, 3'd1, 0, m, e);
        wr(w, 3'd2, 0, mword, e);
        chk("R6 legal mode word", {63'd0, e}, 64'd0);
    endtask

    task automatic enab(input int w, input logic split, input logic exp_err, input string req);
        logic e;
        wr(w, 3'd4, 0, {39'd0, split}, e);
        chk(req, {63'd0, e}, {63'd0, exp_err});
    endtask

    initial begin
        #(CLK_NS * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic v, h, e;
        logic [7:0] p;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R14 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R14 out_hit", {63'd0, out_hit}, 64'd0);
        chk("R14 prog_err", {63'd0, prog_err}, 64'd0);
        look(40'h00_4000_0000, v, h, p);
        chk("R14 empty table miss", {62'd0, v, h}, 64'h2);

        // build the table
        setup(0, 40'h00_4000_0000, M32M, mw(2'd0, 2'd0, 8'h21));
        enab(0, 1'b0, 1'b0, "R2 enable single");
        setup(1, 40'h10_0000_0000, 40'hFF_0000_0000, mw(2'd1, 2'd0, 8'h00));
        enab(1, 1'b1, 1'b0, "R3 enable identity");
        setup(2, 40'h20_0000_0000, 40'hFF_FFFF_0000, mw(2'd2, 2'd0, 8'h00));
        for (int k = 0; k < 8; k++) wr(2, 3'd3, k, 40'(8'h80 + 3*k), e);
        enab(2, 1'b1, 1'b0, "R4 enable table");
        setup(3, 40'h30_0000_0000, 40'hFF_FFF0_0000, mw(2'd3, 2'd1, 8'h40));
        enab(3, 1'b1, 1'b0, "R5 enable offset 64");
        setup(4, 40'hA0_0000_0000, 40'hFF_FFFF_0000, mw(2'd3, 2'd2, 8'h80));
        enab(4, 1'b1, 1'b0, "R5 enable offset 128");
        setup(12, 40'hB0_0000_0000, 40'hFF_FFFF_F000, mw(2'd3, 2'd0, 8'h08));
        enab(12, 1'b1, 1'b0, "R5 enable offset 8");
        setup(5, 40'h10_0000_0000, M32M, mw(2'd0, 2'd0, 8'h77));
        enab(5, 1'b0, 1'b0, "R9 enable overlap");
        setup(6, 40'h40_0000_0000, M32M, mw(2'd0, 2'd0, 8'h55));
        enab(6, 1'b0, 1'b0, "R9 enable win6");
        setup(7, 40'h40_0000_0000, M32M, mw(2'd0, 2'd0, 8'h66));
        enab(7, 1'b0, 1'b0, "R9 enable win7");

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].a, v, h, p);
            chk($sformatf("R1 vec %0d valid", i), {63'd0, v}, 64'd1);
            chk($sformatf("R1 vec %0d hit", i), {63'd0, h}, {63'd0, VECS[i].h});
            chk($sformatf("R2 vec %0d part", i), {56'd0, p}, {56'd0, VECS[i].p});
        end

        // R11: valid low gives no result
        @(negedge clk);
        chk("R11 idle out_valid", {63'd0, out_valid}, 64'd0);

        // R6: refused mode words keep old single config
        setup(8, 40'h60_0000_0000, M32M, mw(2'd0, 2'd0, 8'h12));
        enab(8, 1'b0, 1'b0, "R6 enable win8");
        wr(8, 3'd2, 0, mw(2'd3, 2'd1, 8'h50), e);
        chk("R6 base not multiple err", {63'd0, e}, 64'd1);
        @(negedge clk);
        chk("R6 err one cycle", {63'd0, prog_err}, 64'd0);
        wr(8, 3'd2, 0, mw(2'd3, 2'd3, 8'h00), e);
        chk("R6 count code 3 err", {63'd0, e}, 64'd1);
        look(40'h60_0000_0000, v, h, p);
        chk("R6 config kept", {55'd0, h, p}, {55'd0, 1'b1, 8'h12});

        // R7: undersized single, misaligned base
        setup(9, 40'h70_0000_0000, 40'hFF_FF00_0000, mw(2'd0, 2'd0, 8'h09));
        enab(9, 1'b0, 1'b1, "R7 undersized single err");
        look(40'h70_0000_0000, v, h, p);
        chk("R7 undersized stays off", {55'd0, h, p}, 64'd0);
        setup(10, 40'h70_0100_0000, M32M, mw(2'd0, 2'd0, 8'h0A));
        enab(10, 1'b0, 1'b1, "R7 misaligned err");
        look(40'h70_0100_0000, v, h, p);
        chk("R7 misaligned stays off", {55'd0, h, p}, 64'd0);

        // R8: split request mismatch
        setup(11, 40'h80_0000_0000, 40'hFF_0000_0000, mw(2'd1, 2'd0, 8'h00));
        enab(11, 1'b0, 1'b1, "R8 mismatch err");
        look(40'h80_1200_0000, v, h, p);
        chk("R8 mismatch stays off", {55'd0, h, p}, 64'd0);
        enab(11, 1'b1, 1'b0, "R8 matching split ok");
        look(40'h80_1200_0000, v, h, p);
        chk("R8 enabled identity", {55'd0, h, p}, {55'd0, 1'b1, 8'h12});

        // R12: same-cycle write sees old table, next cycle sees new
        @(negedge clk);
        wr_en = 1'b1; wr_win = 4'd11; wr_op = 3'd5; wr_data = '0;
        in_valid = 1'b1; in_addr = 40'h80_1200_0000;
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        chk("R12 same cycle old table", {55'd0, out_hit, out_part}, {55'd0, 1'b1, 8'h12});
        look(40'h80_1200_0000, v, h, p);
        chk("R13 disabled window misses", {55'd0, h, p}, 64'd0);

        // R13: last window index
        setup(15, 40'h90_0000_0000, M32M, mw(2'd0, 2'd0, 8'h0F));
        enab(15, 1'b0, 1'b0, "R13 enable win15");
        look(40'h90_0000_1234, v, h, p);
        chk("R13 window 15 hit", {55'd0, h, p}, {55'd0, 1'b1, 8'h0F});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule